// File: doc/BRIEF.md
# Flag-Handshake Mailbox Transaction Master

This block drives a byte-wide host window into a small controller that signals its state through two status flags: one says the controller has not yet consumed the last byte the host sent (inbound full), the other says a byte is waiting for the host (outbound full). A client hands the engine one request at a time: a register index, a direction and, for writes, a value. The engine then sequences the byte exchanges on the window, polling the status flags between steps, and reports completion with the read byte or a timeout indication.

Reads are a single exchange: the index goes out as a command and one byte comes back. Writes take two exchanges. The command byte is sent first and the controller answers with a byte that is read and thrown away. The value is sent next and is answered in the same way. The controller keeps several register spaces: a generic space (0) and name-table spaces such as 4 and 5. The engine keeps its own copy of the selected space. It marks a write command with the top bit only while the generic space is selected and only for nonzero indices. Index 0 is the space selector, so a completed write to it changes the tracked space.

Every wait polls the status register at a fixed cycle spacing, up to a parameterised number of polls. When a wait runs out, the transaction is abandoned and reported as timed out.

Top module: `hif_mailbox_master`

## Requirements
- R1: After reset the engine is idle: `reqReady` is 1, `rspDone` and `rspTimeout` are 0, `spaceOut` is 0, and no bus read or write strobe is active.
- R2: Window map: `busAddr`=0 is the data byte (read and write), `busAddr`=1 is the command (write) and status (read); status bit 0 is outbound-full, bit 1 is inbound-full. `busRd` and `busWr` are never active in the same cycle.
- R3: A read polls status until inbound-full is 0, writes the command byte to address 1, polls until outbound-full is 1, reads address 0 once, and returns that byte on `rspData` in the cycle `rspDone` is 1.
- R4: A write does the read sequence of R3 with the returned byte discarded. It then polls until inbound-full is 0, writes the value to address 0, polls until outbound-full is 1 and reads address 0 once more before `rspDone`. That makes exactly two bus writes and two data reads.
- R5: The command byte is the index ORed with 0x80 when the request is a write, the tracked space is 0 and the index is nonzero; in every other case it is the index unchanged.
- R6: `spaceOut` takes the written value when a write to index 0 completes without timeout, and changes at no other time (a timed-out write to index 0 leaves it unchanged).
- R7: Polls within one wait are `POLL_GAP` cycles apart, the first poll comes in the cycle after the wait begins, and no wait issues more than `POLL_LIMIT` status reads.
- R8: When a wait exhausts its polls, `rspDone` and `rspTimeout` are both 1 for exactly one cycle and no further bus write of that transaction occurs.
- R9: A request is taken only when `reqValid` and `reqReady` are both 1; `reqReady` is 0 while a transaction is in flight, and a request presented then has no effect on the bus or on `spaceOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Engine idle and able to take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqIndex | input | BYTE_W | Register index |
| reqData | input | BYTE_W | Value for a write |
| rspData | output | BYTE_W | Byte returned by the last read |
| rspDone | output | 1 | One-cycle completion pulse |
| rspTimeout | output | 1 | One-cycle pulse, with rspDone, when a wait ran out |
| spaceOut | output | BYTE_W | Tracked register space |
| busAddr | output | 1 | Window offset: 0 data, 1 command/status |
| busRd | output | 1 | Window read strobe; busRdata sampled in the same cycle |
| busWr | output | 1 | Window write strobe |
| busWdata | output | BYTE_W | Byte written to the window |
| busRdata | input | BYTE_W | Byte read from the window |

## Verification
On every cycle the assertions check: read/write strobe exclusion, the command byte chosen from the captured request and the tracked space, the data-write value, the bound on status reads per wait, the pairing and single-cycle width of done and timeout, that the engine is busy after accepting, and that the space changes only on a clean completion of a write to index 0. Only the bench scenarios, against a modelled controller with its own latency, can show the exact order and count of exchanges for reads and writes and the returned read data. The same holds for space switching across generic and name spaces, the exact cycle of the last poll before a timeout, and the absence of side effects from a request presented while busy.

// File: rtl/hif_mbx_pkg.sv
package hif_mbx_pkg;

  // window offsets
  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;

  // status bit positions
  localparam int OBF_POS = 0;
  localparam int IBF_POS = 1;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAIT_IN_CMD,
    ST_SEND_CMD,
    ST_WAIT_OUT_CMD,
    ST_TAKE_CMD,
    ST_WAIT_IN_VAL,
    ST_SEND_VAL,
    ST_WAIT_OUT_VAL,
    ST_TAKE_VAL
  } mbxState_e;

  typedef struct packed {
    logic accept;     // latch request fields
    logic pollArm;    // restart poll timer for a new wait
    logic pollProbe;  // issue status read this cycle
    logic pollMiss;   // probe did not satisfy the wait
    logic sendCmd;    // write command byte
    logic sendVal;    // write value byte
    logic takeByte;   // read data byte
    logic finishOk;   // transaction complete
    logic finishTo;   // transaction abandoned
  } mbxStrobes_t;

endpackage

// File: rtl/hif_mbx_datapath.sv
module hif_mbx_datapath
  import hif_mbx_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int POLL_GAP   = 1250,
  parameter int POLL_LIMIT = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  mbxStrobes_t       ctl,
  input  logic              reqWrite,
  input  logic [BYTE_W-1:0] reqIndex,
  input  logic [BYTE_W-1:0] reqData,
  input  logic [BYTE_W-1:0] busRdata,
  output logic              gapDone,
  output logic              pollLast,
  output logic              ibfSeen,
  output logic              obfSeen,
  output logic              isWrite,
  output logic              busAddr,
  output logic              busRd,
  output logic              busWr,
  output logic [BYTE_W-1:0] busWdata,
  output logic [BYTE_W-1:0] rspData,
  output logic              rspDone,
  output logic              rspTimeout,
  output logic [BYTE_W-1:0] spaceOut
);

  localparam int GAP_W = $clog2(POLL_GAP + 1);
  localparam int CNT_W = $clog2(POLL_LIMIT + 1);
  localparam logic [BYTE_W-1:0] WRITE_FLAG = {1'b1, {(BYTE_W-1){1'b0}}};
  localparam logic [BYTE_W-1:0] SPACE_GENERIC = '0;
  localparam logic [BYTE_W-1:0] SELECT_INDEX  = '0;

  logic [BYTE_W-1:0] idxQ, valQ, spaceQ, rdQ;
  logic              wrQ, doneQ, toQ;
  logic [GAP_W-1:0]  gapCnt;
  logic [CNT_W-1:0]  pollCnt;
  logic [BYTE_W-1:0] cmdByte;
  logic              flagOn;

  // request capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ <= '0;
      valQ <= '0;
      wrQ  <= 1'b0;
    end else if (ctl.accept) begin
      idxQ <= reqIndex;
      valQ <= reqData;
      wrQ  <= reqWrite;
    end
  end

  // poll spacing and poll budget
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt  <= '0;
      pollCnt <= '0;
    end else if (ctl.pollArm) begin
      gapCnt  <= '0;
      pollCnt <= '0;
    end else if (ctl.pollMiss) begin
      gapCnt  <= GAP_W'(POLL_GAP - 1);
      pollCnt <= pollCnt + 1'b1;
    end else if (gapCnt != '0) begin
      gapCnt <= gapCnt - 1'b1;
    end
  end

  assign gapDone  = (gapCnt == '0);
  assign pollLast = (pollCnt == CNT_W'(POLL_LIMIT - 1));
  assign ibfSeen  = busRdata[IBF_POS];
  assign obfSeen  = busRdata[OBF_POS];
  assign isWrite  = wrQ;

  // command byte: write marker only in generic space, never for the selector
  assign flagOn  = wrQ && (spaceQ == SPACE_GENERIC) && (idxQ != SELECT_INDEX);
  assign cmdByte = flagOn ? (idxQ | WRITE_FLAG) : idxQ;

  // window drive
  assign busRd    = ctl.pollProbe | ctl.takeByte;
  assign busWr    = ctl.sendCmd | ctl.sendVal;
  assign busAddr  = (ctl.pollProbe | ctl.sendCmd) ? ADDR_CTRL : ADDR_DATA;
  assign busWdata = ctl.sendCmd ? cmdByte : valQ;

  // response and space tracking
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdQ    <= '0;
      doneQ  <= 1'b0;
      toQ    <= 1'b0;
      spaceQ <= SPACE_GENERIC;
    end else begin
      doneQ <= ctl.finishOk | ctl.finishTo;
      toQ   <= ctl.finishTo;
      if (ctl.takeByte && !wrQ) rdQ <= busRdata;
      if (ctl.finishOk && wrQ && (idxQ == SELECT_INDEX)) spaceQ <= valQ;
    end
  end

  assign rspData    = rdQ;
  assign rspDone    = doneQ;
  assign rspTimeout = toQ;
  assign spaceOut   = spaceQ;

endmodule

// File: rtl/hif_mbx_control.sv
module hif_mbx_control
  import hif_mbx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        isWrite,
  input  logic        gapDone,
  input  logic        pollLast,
  input  logic        ibfSeen,
  input  logic        obfSeen,
  output logic        reqReady,
  output mbxStrobes_t ctl
);

  mbxState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    reqReady  = (state == ST_IDLE);
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.accept  = 1'b1;
          ctl.pollArm = 1'b1;
          nextState   = ST_WAIT_IN_CMD;
        end
      end
      ST_WAIT_IN_CMD, ST_WAIT_IN_VAL: begin
        if (gapDone) begin
          ctl.pollProbe = 1'b1;
          if (!ibfSeen) begin
            nextState = (state == ST_WAIT_IN_CMD) ? ST_SEND_CMD : ST_SEND_VAL;
          end else if (pollLast) begin
            ctl.finishTo = 1'b1;
            nextState    = ST_IDLE;
          end else begin
            ctl.pollMiss = 1'b1;
          end
        end
      end
      ST_WAIT_OUT_CMD, ST_WAIT_OUT_VAL: begin
        if (gapDone) begin
          ctl.pollProbe = 1'b1;
          if (obfSeen) begin
            nextState = (state == ST_WAIT_OUT_CMD) ? ST_TAKE_CMD : ST_TAKE_VAL;
          end else if (pollLast) begin
            ctl.finishTo = 1'b1;
            nextState    = ST_IDLE;
          end else begin
            ctl.pollMiss = 1'b1;
          end
        end
      end
      ST_SEND_CMD: begin
        ctl.sendCmd = 1'b1;
        ctl.pollArm = 1'b1;
        nextState   = ST_WAIT_OUT_CMD;
      end
      ST_TAKE_CMD: begin
        ctl.takeByte = 1'b1;
        if (isWrite) begin
          ctl.pollArm = 1'b1;
          nextState   = ST_WAIT_IN_VAL;
        end else begin
          ctl.finishOk = 1'b1;
          nextState    = ST_IDLE;
        end
      end
      ST_SEND_VAL: begin
        ctl.sendVal = 1'b1;
        ctl.pollArm = 1'b1;
        nextState   = ST_WAIT_OUT_VAL;
      end
      ST_TAKE_VAL: begin
        ctl.takeByte = 1'b1;
        ctl.finishOk = 1'b1;
        nextState    = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/hif_mailbox_master.sv
module hif_mailbox_master
  import hif_mbx_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int POLL_GAP   = 1250,
  parameter int POLL_LIMIT = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [BYTE_W-1:0] reqIndex,
  input  logic [BYTE_W-1:0] reqData,
  output logic [BYTE_W-1:0] rspData,
  output logic              rspDone,
  output logic              rspTimeout,
  output logic [BYTE_W-1:0] spaceOut,
  output logic              busAddr,
  output logic              busRd,
  output logic              busWr,
  output logic [BYTE_W-1:0] busWdata,
  input  logic [BYTE_W-1:0] busRdata
);

  mbxStrobes_t ctl;
  logic gapDone, pollLast, ibfSeen, obfSeen, isWrite;

  hif_mbx_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .isWrite  (isWrite),
    .gapDone  (gapDone),
    .pollLast (pollLast),
    .ibfSeen  (ibfSeen),
    .obfSeen  (obfSeen),
    .reqReady (reqReady),
    .ctl      (ctl)
  );

  hif_mbx_datapath #(
    .BYTE_W     (BYTE_W),
    .POLL_GAP   (POLL_GAP),
    .POLL_LIMIT (POLL_LIMIT)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .reqWrite   (reqWrite),
    .reqIndex   (reqIndex),
    .reqData    (reqData),
    .busRdata   (busRdata),
    .gapDone    (gapDone),
    .pollLast   (pollLast),
    .ibfSeen    (ibfSeen),
    .obfSeen    (obfSeen),
    .isWrite    (isWrite),
    .busAddr    (busAddr),
    .busRd      (busRd),
    .busWr      (busWr),
    .busWdata   (busWdata),
    .rspData    (rspData),
    .rspDone    (rspDone),
    .rspTimeout (rspTimeout),
    .spaceOut   (spaceOut)
  );

endmodule

// File: rtl/hif_mailbox_master_chk.sv
module hif_mailbox_master_chk #(
  parameter int BYTE_W     = 8,
  parameter int POLL_LIMIT = 1000
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              reqWrite,
  input logic [BYTE_W-1:0] reqIndex,
  input logic [BYTE_W-1:0] reqData,
  input logic              rspDone,
  input logic              rspTimeout,
  input logic [BYTE_W-1:0] spaceOut,
  input logic              busAddr,
  input logic              busRd,
  input logic              busWr,
  input logic [BYTE_W-1:0] busWdata
);

  localparam int RUN_W = $clog2(POLL_LIMIT + 1) + 1;
  localparam logic [BYTE_W-1:0] MARK = {1'b1, {(BYTE_W-1){1'b0}}};

  logic [BYTE_W-1:0] seenIdx, seenData;
  logic              seenWr;
  logic [RUN_W-1:0]  statusRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenIdx   <= '0;
      seenData  <= '0;
      seenWr    <= 1'b0;
      statusRun <= '0;
    end else begin
      if (reqValid && reqReady) begin
        seenIdx  <= reqIndex;
        seenData <= reqData;
        seenWr   <= reqWrite;
      end
      if ((reqValid && reqReady) || busWr || (busRd && !busAddr))
        statusRun <= '0;
      else if (busRd && busAddr)
        statusRun <= statusRun + 1'b1;
    end
  end

  p_rdwr_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && busWr));

  p_cmd_marked_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr && seenWr && spaceOut == '0 && seenIdx != '0)
      |-> busWdata == (seenIdx | MARK));

  p_cmd_plain_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr && !(seenWr && spaceOut == '0 && seenIdx != '0))
      |-> busWdata == seenIdx);

  p_value_byte_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !busAddr) |-> (seenWr && busWdata == seenData));

  p_space_change_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(spaceOut) |-> (rspDone && !rspTimeout && seenWr &&
                            seenIdx == '0 && spaceOut == seenData));

  p_poll_budget_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr) |-> statusRun < RUN_W'(POLL_LIMIT));

  p_timeout_with_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspTimeout |-> rspDone);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!busRd && !busWr));

endmodule

bind hif_mailbox_master hif_mailbox_master_chk #(
  .BYTE_W     (BYTE_W),
  .POLL_LIMIT (POLL_LIMIT)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .reqWrite   (reqWrite),
  .reqIndex   (reqIndex),
  .reqData    (reqData),
  .rspDone    (rspDone),
  .rspTimeout (rspTimeout),
  .spaceOut   (spaceOut),
  .busAddr    (busAddr),
  .busRd      (busRd),
  .busWr      (busWr),
  .busWdata   (busWdata)
);

// File: tb/hif_mailbox_master_bench.sv
module hif_mailbox_master_bench;

  localparam int BYTE_W = 8;
  localparam int GAP    = 3;
  localparam int LIMIT  = 20;
  localparam int LAT    = 5;
  localparam int NVEC   = 14;

  // {write, index, value, expected read, expected command byte, expected space}
  localparam logic [40:0] VECS [NVEC] = '{
    {1'b0, 8'h7E, 8'h00, 8'h55, 8'h7E, 8'h00},
    {1'b0, 8'h7F, 8'h00, 8'hAA, 8'h7F, 8'h00},
    {1'b1, 8'h31, 8'h03, 8'h00, 8'hB1, 8'h00},
    {1'b0, 8'h31, 8'h00, 8'h03, 8'h31, 8'h00},
    {1'b1, 8'h00, 8'h04, 8'h00, 8'h00, 8'h04},
    {1'b0, 8'h41, 8'h00, 8'h45, 8'h41, 8'h04},
    {1'b0, 8'hC3, 8'h00, 8'hC7, 8'hC3, 8'h04},
    {1'b1, 8'h50, 8'h11, 8'h00, 8'h50, 8'h04},
    {1'b1, 8'h00, 8'h05, 8'h00, 8'h00, 8'h05},
    {1'b0, 8'h42, 8'h00, 8'h47, 8'h42, 8'h05},
    {1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
    {1'b1, 8'h32, 8'h7E, 8'h00, 8'hB2, 8'h00},
    {1'b0, 8'h32, 8'h00, 8'h7E, 8'h32, 8'h00},
    {1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [7:0] reqIndex = '0, reqData = '0;
  logic reqReady, rspDone, rspTimeout, busAddr, busRd, busWr;
  logic [7:0] rspData, spaceOut, busWdata, busRdata;

  always #4 clk = ~clk;

  hif_mailbox_master #(.BYTE_W(BYTE_W), .POLL_GAP(GAP), .POLL_LIMIT(LIMIT)) u_hif_mailbox_master (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqIndex(reqIndex), .reqData(reqData),
    .rspData(rspData), .rspDone(rspDone), .rspTimeout(rspTimeout),
    .spaceOut(spaceOut), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata)
  );

  // ---------------- controller model ----------------
  logic stuckIbf = 1'b0, stuckObf = 1'b0;
  logic tIbf, tObf, tValPhase;
  logic [7:0] tOut, tPend, tDat, tSpace;
  logic [7:0] tMem [128];
  int tLat;
  int cyc = 0, stRds = 0, dRds = 0, wrCnt = 0, lastSt = 0;
  logic [7:0] lastCmd = '0, lastVal = '0;

  assign busRdata = busAddr ? {6'b0, tIbf | stuckIbf, tObf} : tOut;

  function automatic logic [7:0] tRead(input logic [7:0] idx);
    if (tSpace != 8'h00)      return idx + tSpace;
    else if (idx == 8'h7E)    return 8'h55;
    else if (idx == 8'h7F)    return 8'hAA;
    else                      return tMem[idx[6:0]];
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (!rstN) begin
      tIbf <= 1'b0; tObf <= 1'b0; tValPhase <= 1'b0;
      tOut <= '0; tPend <= '0; tDat <= '0; tSpace <= '0; tLat <= 0;
      for (int i = 0; i < 128; i++) tMem[i] <= '0;
    end else begin
      if (busRd && busAddr) begin stRds <= stRds + 1; lastSt <= cyc; end
      if (busRd && !busAddr) begin dRds <= dRds + 1; tObf <= 1'b0; end
      if (busWr && busAddr) begin
        wrCnt <= wrCnt + 1; lastCmd <= busWdata; tPend <= busWdata;
        tIbf <= 1'b1; tValPhase <= 1'b0; tLat <= LAT;
      end else if (busWr && !busAddr) begin
        wrCnt <= wrCnt + 1; lastVal <= busWdata; tDat <= busWdata;
        tIbf <= 1'b1; tValPhase <= 1'b1; tLat <= LAT;
      end else if (tLat > 0) begin
        tLat <= tLat - 1;
        if (tLat == 1) begin
          tIbf <= 1'b0;
          if (!stuckObf) tObf <= 1'b1;
          if (!tValPhase) begin
            if ((tSpace == 8'h00 && tPend[7]) || tPend == 8'h00) tOut <= 8'h00;
            else tOut <= tRead(tPend);
          end else begin
            if (tSpace == 8'h00 && tPend[7]) tMem[tPend[6:0]] <= tDat;
            else if (tPend == 8'h00) tSpace <= tDat;
            tOut <= 8'h00;
          end
        end
      end
    end
  end

  // ---------------- checking ----------------
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic runTxn(input logic wr, input logic [7:0] idx, input logic [7:0] dat,
                        output logic [7:0] rd, output logic to, output int accCyc);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqIndex = idx; reqData = dat;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    accCyc = cyc;
    while (!rspDone) @(negedge clk);
    rd = rspData;
    to = rspTimeout;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic to;
    int acc, w0, d0, s0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(reqReady == 1'b1, "R1 ready", reqReady, 1);
    chk(rspDone == 1'b0 && rspTimeout == 1'b0, "R1 done/timeout", {rspDone, rspTimeout}, 0);
    chk(spaceOut == 8'h00, "R1 space", spaceOut, 0);
    chk(!busRd && !busWr, "R1 bus idle", {busRd, busWr}, 0);

    // table walk: R2 R3 R4 R5 R6
    for (int v = 0; v < NVEC; v++) begin
      logic [40:0] e;
      e = VECS[v];
      w0 = wrCnt; d0 = dRds;
      runTxn(e[40], e[39:32], e[31:24], rd, to, acc);
      chk(to == 1'b0, "R8 no timeout", to, 0);
      chk(lastCmd == e[15:8], "R5 command byte", lastCmd, e[15:8]);
      chk(spaceOut == e[7:0], "R6 space", spaceOut, e[7:0]);
      if (e[40]) begin
        chk(wrCnt - w0 == 2, "R4 bus writes", wrCnt - w0, 2);
        chk(dRds - d0 == 2, "R4 data reads", dRds - d0, 2);
        chk(lastVal == e[31:24], "R4 value byte", lastVal, e[31:24]);
      end else begin
        chk(wrCnt - w0 == 1, "R3 bus writes", wrCnt - w0, 1);
        chk(dRds - d0 == 1, "R3 data reads", dRds - d0, 1);
        chk(rd == e[23:16], "R3 read data R2 map", rd, e[23:16]);
      end
    end

    // R9: request held while busy has no effect
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqIndex = 8'h31; reqData = 8'h00;
    @(posedge clk);
    @(negedge clk);
    reqWrite = 1'b1; reqIndex = 8'h00; reqData = 8'h09;
    chk(reqReady == 1'b0, "R9 busy not ready", reqReady, 0);
    repeat (3) @(negedge clk);
    reqValid = 1'b0;
    w0 = wrCnt;
    while (!rspDone) @(negedge clk);
    chk(rspData == 8'h03, "R9 first request completes", rspData, 8'h03);
    repeat (20) @(negedge clk);
    chk(wrCnt == w0, "R9 no extra bus writes", wrCnt - w0, 0);
    chk(spaceOut == 8'h00, "R9 space untouched", spaceOut, 0);
    chk(lastCmd == 8'h31, "R9 command kept", lastCmd, 8'h31);

    // R7 R8: inbound-full stuck
    stuckIbf = 1'b1;
    s0 = stRds; w0 = wrCnt;
    runTxn(1'b0, 8'h31, 8'h00, rd, to, acc);
    chk(to == 1'b1, "R8 timeout flagged", to, 1);
    chk(stRds - s0 == LIMIT, "R7 poll count", stRds - s0, LIMIT);
    chk(lastSt == acc + (LIMIT - 1) * GAP, "R7 poll spacing", lastSt - acc, (LIMIT - 1) * GAP);
    chk(wrCnt == w0, "R8 no command after timeout", wrCnt - w0, 0);
    @(negedge clk);
    chk(rspDone == 1'b0 && rspTimeout == 1'b0, "R8 single-cycle pulse", {rspDone, rspTimeout}, 0);
    stuckIbf = 1'b0;

    // R6 R8: outbound-full never set on a selector write
    stuckObf = 1'b1;
    s0 = stRds; w0 = wrCnt;
    runTxn(1'b1, 8'h00, 8'h04, rd, to, acc);
    chk(to == 1'b1, "R8 timeout on write", to, 1);
    chk(stRds - s0 == LIMIT + 1, "R7 polls across waits", stRds - s0, LIMIT + 1);
    chk(wrCnt - w0 == 1, "R8 value not sent", wrCnt - w0, 1);
    chk(spaceOut == 8'h00, "R6 space kept after timeout", spaceOut, 0);
    stuckObf = 1'b0;
    repeat (LAT + 2) @(negedge clk);

    // R3 recovery read
    runTxn(1'b0, 8'h7E, 8'h00, rd, to, acc);
    chk(rd == 8'h55 && to == 1'b0, "R3 recovery read", rd, 8'h55);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule